// File: doc/BRIEF.md
# Timer Input-Capture Channel

This block is one capture channel attached to a free-running timer. It watches an input pin through a synchroniser. When the selected transition arrives it copies the timer count into a capture register, raises an event flag and, if interrupts are enabled, requests an interrupt. The edge selection can be rising only, falling only or both. With both edges selected, a pulse can be timed on a single channel without rewriting the configuration between its two edges.

Software uses one 8-bit control/status register and a read-only capture value. The register holds these fields:

- Bit 7 is the event flag. It is cleared by writing 1 to it.
- Bit 6 enables the interrupt.
- Bits 3:2 select the edge.

The remaining bits read as zero. A flag clear that arrives after a further event has already been recorded is refused. This means an event that occurs while an earlier one is being serviced is never lost. Changes to the edge selection pass through a short internal delay before they apply.

Top module: `capch_channel`

## Requirements
- R1: After reset, the control/status read value is 0x00, the capture value is 0 and the interrupt request is low.
- R2: With bits 3:2 = 01 (rising only), a low-to-high pin change seen at clock edge k sets the flag at edge k+2. At the same edge, the capture register takes the count value presented at edge k+2. A high-to-low change does nothing.
- R3: With bits 3:2 = 10 (falling only), only high-to-low pin changes capture and set the flag, using the same k+2 timing.
- R4: With bits 3:2 = 11, both pin transitions capture and set the flag, using the same k+2 timing.
- R5: With bits 3:2 = 00 the channel is off: pin changes neither capture nor touch the flag.
- R6: A register write shows in the read value at once. The edge selection it carries becomes active at the second clock edge after the edge that accepts the write. Until then, edges are judged against the previous selection.
- R7: Writing 1 to bit 7 clears the flag when no event is pending behind it. Writing 0 to bit 7 leaves the flag unchanged.
- R8: If a further event is recorded while the flag is already set, the next clear write leaves the flag set. The clear write after that one clears it.
- R9: A clear write accepted at the same clock edge as a new event leaves the flag set. The following clear write then clears it.
- R10: The interrupt request equals flag AND bit 6 at every cycle.
- R11: Every qualifying edge reloads the capture register, even when the flag is already set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| pin_i | input | 1 | Asynchronous capture input |
| cnt_i | input | CNT_W | Free-running timer count |
| csr_we_i | input | 1 | Write strobe for the control/status register |
| csr_wdata_i | input | 8 | Write data |
| csr_rdata_o | output | 8 | Control/status read value |
| cap_o | output | CNT_W | Last captured count |
| irq_o | output | 1 | Interrupt request |

## Verification
A pin change applied before clock edge k is due as a flag and capture at edge k+2. A register write applied before edge w shows in the read value after w, but it governs edge qualification only from the evaluation at edge w+3 onward.

The bench drives all inputs just after a falling clock edge and samples every output at the next falling edge. Its reference model advances once per rising edge with the same register counts. Directed checks therefore wait exactly three falling edges after a pin change, and they place the clear write on the same rising edge as the event when testing the race.

// File: rtl/capch_pkg.sv
package capch_pkg;

  typedef enum logic [1:0] {
    EDGE_NONE = 2'b00,
    EDGE_RISE = 2'b01,
    EDGE_FALL = 2'b10,
    EDGE_BOTH = 2'b11
  } edge_sel_e;

  localparam int unsigned CSR_W    = 8;
  localparam int unsigned FLAG_BIT = 7;
  localparam int unsigned IE_BIT   = 6;
  localparam int unsigned SEL_HI   = 3;
  localparam int unsigned SEL_LO   = 2;

endpackage

// File: rtl/capch_sync_edge.sv
module capch_sync_edge #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pin_i,
  output logic rise_o,
  output logic fall_o
);
  localparam int unsigned LEN = STAGES + 1;

  logic [LEN-1:0] shf_q;
  logic [LEN-1:0] shf_d;

  always_comb begin
    shf_d = {shf_q[LEN-2:0], pin_i};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      shf_q <= '0;
    end else begin
      shf_q <= shf_d;
    end
  end

  // newest synchronised sample against the one before it
  assign rise_o = shf_q[LEN-2] & ~shf_q[LEN-1];
  assign fall_o = ~shf_q[LEN-2] & shf_q[LEN-1];

endmodule

// File: rtl/capch_cfg_pipe.sv
module capch_cfg_pipe #(
  parameter int unsigned W     = 2,
  parameter int unsigned DEPTH = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stg_q [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_stage
    logic [W-1:0] stg_d;
    if (g == 0) begin : g_head
      assign stg_d = d_i;
    end else begin : g_body
      assign stg_d = stg_q[g-1];
    end
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        stg_q[g] <= '0;
      end else begin
        stg_q[g] <= stg_d;
      end
    end
  end

  assign q_o = stg_q[DEPTH-1];

endmodule

// File: rtl/capch_flag.sv
module capch_flag (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic evt_i,
  input  logic clr_i,
  output logic flag_o,
  output logic pend_o
);
  logic flag_q, flag_d;
  logic pend_q, pend_d;

  always_comb begin
    flag_d = flag_q;
    pend_d = pend_q;
    if (clr_i) begin
      // a clear only succeeds when nothing arrived behind the flag
      flag_d = evt_i | pend_q;
      pend_d = 1'b0;
    end else if (evt_i) begin
      flag_d = 1'b1;
      pend_d = flag_q;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flag_q <= 1'b0;
      pend_q <= 1'b0;
    end else begin
      flag_q <= flag_d;
      pend_q <= pend_d;
    end
  end

  assign flag_o = flag_q;
  assign pend_o = pend_q;

endmodule

// File: rtl/capch_channel.sv
module capch_channel
  import capch_pkg::*;
#(
  parameter int unsigned CNT_W       = 16,
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned CFG_DELAY   = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             pin_i,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic             csr_we_i,
  input  logic [7:0]       csr_wdata_i,
  output logic [7:0]       csr_rdata_o,
  output logic [CNT_W-1:0] cap_o,
  output logic             irq_o
);
  localparam int unsigned SEL_W = SEL_HI - SEL_LO + 1;

  // software-visible configuration
  logic      ie_q, ie_d;
  edge_sel_e sel_q, sel_d;
  logic      cfg_en;

  assign cfg_en = csr_we_i;

  always_comb begin
    ie_d  = csr_wdata_i[IE_BIT];
    sel_d = edge_sel_e'(csr_wdata_i[SEL_HI:SEL_LO]);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ie_q  <= 1'b0;
      sel_q <= EDGE_NONE;
    end else if (cfg_en) begin
      ie_q  <= ie_d;
      sel_q <= sel_d;
    end
  end

  // delayed copy of the edge selection that actually qualifies edges
  logic [SEL_W-1:0] act_sel;

  capch_cfg_pipe #(
    .W     (SEL_W),
    .DEPTH (CFG_DELAY)
  ) cfg_pipe_i (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (sel_q),
    .q_o    (act_sel)
  );

  logic rise, fall;

  capch_sync_edge #(
    .STAGES (SYNC_STAGES)
  ) sync_i (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .pin_i  (pin_i),
    .rise_o (rise),
    .fall_o (fall)
  );

  logic evt;
  assign evt = (rise & act_sel[0]) | (fall & act_sel[1]);

  logic clr;
  assign clr = csr_we_i & csr_wdata_i[FLAG_BIT];

  logic flag, flag_pend;

  capch_flag flag_i (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .evt_i  (evt),
    .clr_i  (clr),
    .flag_o (flag),
    .pend_o (flag_pend)
  );

  // capture register: reloads on every qualifying edge
  logic [CNT_W-1:0] cap_q, cap_d;
  logic             cap_en;

  assign cap_en = evt;

  always_comb begin
    cap_d = cnt_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cap_q <= '0;
    end else if (cap_en) begin
      cap_q <= cap_d;
    end
  end

  always_comb begin
    csr_rdata_o                = '0;
    csr_rdata_o[FLAG_BIT]      = flag;
    csr_rdata_o[IE_BIT]        = ie_q;
    csr_rdata_o[SEL_HI:SEL_LO] = sel_q;
  end

  assign cap_o = cap_q;
  assign irq_o = flag & ie_q;

endmodule

// File: rtl/capch_channel_chk.sv
module capch_channel_chk #(
  parameter int unsigned CNT_W = 16
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             csr_we_i,
  input logic [7:0]       csr_wdata_i,
  input logic [7:0]       csr_rdata_o,
  input logic [CNT_W-1:0] cap_o,
  input logic             irq_o,
  input logic             evt_i,
  input logic             pend_i,
  input logic [1:0]       act_sel_i
);

  // R10
  irq_match_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o == (csr_rdata_o[7] & csr_rdata_o[6]));

  // R2
  evt_sets_flag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    evt_i |=> csr_rdata_o[7]);

  // R7
  flag_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (csr_rdata_o[7] && !(csr_we_i && csr_wdata_i[7])) |=> csr_rdata_o[7]);

  // R7
  flag_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (csr_we_i && csr_wdata_i[7] && !evt_i && !pend_i) |=> !csr_rdata_o[7]);

  // R8
  pend_keeps_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (csr_we_i && csr_wdata_i[7] && pend_i) |=> csr_rdata_o[7]);

  // R9
  race_evt_wins_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (csr_we_i && csr_wdata_i[7] && evt_i) |=> csr_rdata_o[7]);

  // R11
  cap_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !evt_i |=> $stable(cap_o));

  // R5
  off_no_evt_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (act_sel_i == 2'b00) |-> !evt_i);

endmodule

bind capch_channel capch_channel_chk #(.CNT_W(CNT_W)) chk_i (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .csr_we_i    (csr_we_i),
  .csr_wdata_i (csr_wdata_i),
  .csr_rdata_o (csr_rdata_o),
  .cap_o       (cap_o),
  .irq_o       (irq_o),
  .evt_i       (evt),
  .pend_i      (flag_pend),
  .act_sel_i   (act_sel)
);

// File: tb/capch_channel_tb_top.sv
module capch_channel_tb_top;
  localparam int unsigned CNT_W = 16;

  logic             clk = 1'b0;
  logic             rst_n;
  logic             pin;
  logic [CNT_W-1:0] cnt;
  logic             we;
  logic [7:0]       wdata;
  logic [7:0]       rdata;
  logic [CNT_W-1:0] cap;
  logic             irq;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;

  capch_channel #(.CNT_W(CNT_W)) dut_i (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .pin_i       (pin),
    .cnt_i       (cnt),
    .csr_we_i    (we),
    .csr_wdata_i (wdata),
    .csr_rdata_o (rdata),
    .cap_o       (cap),
    .irq_o       (irq)
  );

  // reference model built from the requirements, advanced per rising edge
  logic [2:0]       m_s;
  logic [1:0]       m_d1, m_act, m_sel;
  logic             m_ie, m_flag, m_pend, m_ev, m_clr;
  logic [CNT_W-1:0] m_cap;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_s = '0; m_d1 = '0; m_act = '0; m_sel = '0;
      m_ie = 1'b0; m_flag = 1'b0; m_pend = 1'b0; m_cap = '0;
    end else begin
      m_ev  = (m_s[1] & ~m_s[2] & m_act[0]) | (~m_s[1] & m_s[2] & m_act[1]);
      m_clr = we & wdata[7];
      if (m_clr) begin
        m_flag = m_ev | m_pend;
        m_pend = 1'b0;
      end else if (m_ev) begin
        m_pend = m_flag;
        m_flag = 1'b1;
      end
      if (m_ev) m_cap = cnt;
      m_act = m_d1;
      m_d1  = m_sel;
      if (we) begin
        m_ie  = wdata[6];
        m_sel = wdata[3:2];
      end
      m_s = {m_s[1:0], pin};
    end
  end

  function automatic logic [7:0] exp_csr();
    return {m_flag, m_ie, 2'b00, m_sel, 2'b00};
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
    chk(rdata[7] == exp_csr()[7], "R8 model flag", 32'(rdata[7]), 32'(exp_csr()[7]));
    chk(rdata[6:0] == exp_csr()[6:0], "R6 model config", 32'(rdata), 32'(exp_csr()));
    chk(cap == m_cap, "R11 model capture", 32'(cap), 32'(m_cap));
    chk(irq == (m_flag & m_ie), "R10 model irq", 32'(irq), 32'(m_flag & m_ie));
    cnt = cnt + 1'b1;
    we  = 1'b0;
  endtask

  task automatic wcfg(input logic [7:0] d);
    we    = 1'b1;
    wdata = d;
    tick();
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) tick();
  endtask

  task automatic report();
    $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=running expected=finished");
      report();
    end
  end

  initial begin
    logic [CNT_W-1:0] c0;
    void'($urandom(32'd2024));
    rst_n = 1'b0; pin = 1'b0; cnt = '0; we = 1'b0; wdata = '0;
    ticks(3);
    rst_n = 1'b1;
    tick();
    // R1 reset values
    chk(rdata == 8'h00, "R1 csr", 32'(rdata), 0);
    chk(cap == '0, "R1 cap", 32'(cap), 0);
    chk(irq == 1'b0, "R1 irq", 32'(irq), 0);

    // R2 rising only, with interrupt
    wcfg(8'h44); ticks(3);
    pin = 1'b1; c0 = cnt;
    ticks(2);
    chk(rdata[7] == 1'b0, "R2 latency", 32'(rdata[7]), 0);
    tick();
    chk(rdata[7] == 1'b1, "R2 flag", 32'(rdata[7]), 1);
    chk(cap == c0 + 2, "R2 cap", 32'(cap), 32'(c0 + 2));
    chk(irq == 1'b1, "R10 irq on", 32'(irq), 1);

    // R7 writing 0 to the flag bit keeps it, writing 1 clears it
    wcfg(8'h44);
    chk(rdata[7] == 1'b1, "R7 keep", 32'(rdata[7]), 1);
    wcfg(8'hC4);
    chk(rdata[7] == 1'b0, "R7 clear", 32'(rdata[7]), 0);
    chk(irq == 1'b0, "R10 irq off", 32'(irq), 0);

    // R2 falling edge ignored under rising-only
    pin = 1'b0; ticks(4);
    chk(rdata[7] == 1'b0, "R2 fall ignored", 32'(rdata[7]), 0);
    chk(cap == c0 + 2, "R2 cap kept", 32'(cap), 32'(c0 + 2));

    // R6 disable write still sees the old selection for two clocks
    pin = 1'b1; c0 = cnt;
    wcfg(8'h00);
    chk(rdata == 8'h00, "R6 readback", 32'(rdata), 0);
    ticks(2);
    chk(rdata[7] == 1'b1, "R6 old sel flag", 32'(rdata[7]), 1);
    chk(cap == c0 + 2, "R6 old sel cap", 32'(cap), 32'(c0 + 2));
    wcfg(8'h80);

    // R5 channel off
    c0 = cap;
    pin = 1'b0; ticks(3);
    pin = 1'b1; ticks(3);
    chk(rdata[7] == 1'b0, "R5 flag", 32'(rdata[7]), 0);
    chk(cap == c0, "R5 cap", 32'(cap), 32'(c0));

    // R6 enable write does not yet apply to a coincident edge
    pin = 1'b0;
    wcfg(8'h48); ticks(3);
    chk(rdata[7] == 1'b0, "R6 new sel late", 32'(rdata[7]), 0);

    // R3 falling only
    pin = 1'b1; ticks(3);
    chk(rdata[7] == 1'b0, "R3 rise ignored", 32'(rdata[7]), 0);
    pin = 1'b0; c0 = cnt; ticks(3);
    chk(rdata[7] == 1'b1, "R3 flag", 32'(rdata[7]), 1);
    chk(cap == c0 + 2, "R3 cap", 32'(cap), 32'(c0 + 2));
    wcfg(8'hC8);

    // R4 both edges
    wcfg(8'h4C); ticks(3);
    pin = 1'b1; c0 = cnt; ticks(3);
    chk(cap == c0 + 2, "R4 rise cap", 32'(cap), 32'(c0 + 2));
    wcfg(8'hCC);
    pin = 1'b0; c0 = cnt; ticks(3);
    chk(cap == c0 + 2, "R4 fall cap", 32'(cap), 32'(c0 + 2));
    chk(rdata[7] == 1'b1, "R4 flag", 32'(rdata[7]), 1);

    // R11 reload while flag already set
    pin = 1'b1; c0 = cnt; ticks(3);
    chk(cap == c0 + 2, "R11 reload", 32'(cap), 32'(c0 + 2));

    // R8 pending event refuses the first clear
    wcfg(8'hCC);
    chk(rdata[7] == 1'b1, "R8 refused", 32'(rdata[7]), 1);
    wcfg(8'hCC);
    chk(rdata[7] == 1'b0, "R8 second clear", 32'(rdata[7]), 0);

    // R9 clear in the same cycle as an event
    pin = 1'b0; ticks(3);
    pin = 1'b1; c0 = cnt; ticks(2);
    wcfg(8'hCC);
    chk(rdata[7] == 1'b1, "R9 event wins", 32'(rdata[7]), 1);
    chk(cap == c0 + 2, "R9 cap", 32'(cap), 32'(c0 + 2));
    wcfg(8'hCC);
    chk(rdata[7] == 1'b0, "R9 next clear", 32'(rdata[7]), 0);

    // random traffic checked against the model
    for (int i = 0; i < 4000; i++) begin
      if ($urandom_range(4) == 0) pin = ~pin;
      if ($urandom_range(9) == 0) begin
        we    = 1'b1;
        wdata = {1'($urandom_range(1)), 1'($urandom_range(1)), 2'b00,
                 2'($urandom_range(3)), 2'b00};
      end
      tick();
    end

    done = 1'b1;
    report();
  end

endmodule